// File: doc/BRIEF.md
# Interrupt-on-change mismatch detector

This block watches a group of input pins and raises a sticky interrupt flag when an enabled pin no longer matches a stored reference value. The reference is a snapshot of the synchronised pin values. The snapshot is reloaded every time software reads or writes the port through the register bus, not on every clock. Each pin has its own change-enable bit. The per-pin mismatches are ORed into one change flag, and the same flag drives a wake request for the sleep controller.

Software services the interrupt in two steps. It first reads or writes the port, which reloads the snapshot and ends the mismatch. It then writes 0 to the flag bit. A clear that arrives while a mismatch still exists has no lasting effect, because a set condition always wins over a clear.

The snapshot and the enable bits are reset only by power-on reset. A master or brown-out reset clears the flag but keeps the reference, so a mismatch that still exists after that reset sets the flag again.

Top module: `ioc_mismatch_top`

## Requirements
- R1: The change-enable register sits at bus address 1, with bit i enabling pin i. Power-on reset clears it to 0. A master reset (`rst_n` low) leaves it unchanged. A bus write at address 1 loads it, and a bus read at address 1 returns it.
- R2: A pin whose enable bit is 0 never sets the flag, whatever its value does.
- R3: The flag is set when at least one enabled synchronised pin differs from its snapshot bit. The flag is 1 from the first clock edge after that mismatch appears, and the mismatches of all pins are ORed together.
- R4: The flag is sticky. A bus write at address 2 with data bit 0 equal to 0 clears it, but only when no enabled mismatch exists in that cycle: set takes priority over clear. A write at address 2 with bit 0 equal to 1 has no effect.
- R5: A bus read or a bus write at address 0 loads the snapshot with the synchronised pin values at the clock edge that ends the access. A read at address 0 returns those synchronised values. Any other address reads as 0.
- R6: If a pin's synchronised value changes in the same cycle as a port access, the flag is still set, because that cycle compares against the old snapshot.
- R7: A master reset clears the flag asynchronously and does not alter the snapshot. If a mismatch exists after the release, the flag is 1 again after the first clock edge.
- R8: `wake_req` equals the flag at all times. Both are 0 during and right after power-on reset.
- R9: The pins pass through two synchroniser flops. A change driven on the pins therefore shows on the flag after the third rising clock edge, and not before.
- R10: After power-on reset the snapshot fills itself from the synchronised pins, so non-zero pins at power-up never cause a flag, even when every enable is later set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Master or brown-out reset, active low, asynchronous; clears only the flag |
| pins_in | input | N_PINS | Asynchronous pin inputs |
| bus_rd | input | 1 | Register bus read strobe |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W | Register address: 0 port, 1 change enables, 2 flag |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational, 0 when no read |
| change_flag | output | 1 | Sticky change interrupt flag |
| wake_req | output | 1 | Wake request to the sleep controller |

## Verification
The bench targets four cases. A toggle on a disabled pin must leave the flag low; a design that ignored the enable mask would raise it. A flag clear issued before a port access must fail, and the same clear must succeed after a port read; a design without set-over-clear priority would drop the flag while the mismatch still existed. A pin change that lands in the very cycle of a port read must still set the flag; a design that compared against the newly loaded snapshot would miss it. A master reset pulse must leave the snapshot in place, so the flag returns after the release; a design that reset the reference would stay quiet. Random traffic, with its own expected values, then runs against all of these rules.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int unsigned REG_PORT = 0;
    localparam int unsigned REG_EN   = 1;
    localparam int unsigned REG_FLAG = 2;
    localparam int unsigned FLAG_BIT = 0;

    typedef struct packed {
        logic port_acc;
        logic en_wr;
        logic flag_clr;
    } ioc_op_t;

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.stg[STAGES-1];

endmodule

// File: rtl/ioc_snapshot.sv
module ioc_snapshot #(
    parameter int unsigned W     = 8,
    parameter int unsigned PRIME = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] pin_s,
    input  logic         load,
    output logic [W-1:0] snap,
    output logic         valid
);

    localparam int unsigned CNT_W = $clog2(PRIME + 1);

    typedef struct packed {
        logic [W-1:0]     snap;
        logic [CNT_W-1:0] cnt;
    } snap_state_t;

    snap_state_t s_d, s_q;

    assign valid = (s_q.cnt == CNT_W'(PRIME));
    assign snap  = s_q.snap;

    // Priming: follow the pins until the synchroniser holds real values.
    always_comb begin
        s_d = s_q;
        if (!valid) begin
            s_d.snap = pin_s;
            s_d.cnt  = s_q.cnt + CNT_W'(1);
        end else if (load) begin
            s_d.snap = pin_s;
        end
    end

    // Only power-on reset reaches this register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ioc_compare.sv
module ioc_compare #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] snap,
    input  logic [W-1:0] en,
    input  logic         valid,
    output logic [W-1:0] mis_vec,
    output logic         mis_any
);

    for (genvar i = 0; i < int'(W); i++) begin : g_pin
        always_comb begin
            mis_vec[i] = valid & en[i] & (pin_s[i] ^ snap[i]);
        end
    end

    assign mis_any = |mis_vec;

endmodule

// File: rtl/ioc_regs.sv
module ioc_regs
    import ioc_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [W-1:0]      pin_s,
    input  logic              mis_any,
    output logic [W-1:0]      en,
    output logic              flag,
    output logic [DATA_W-1:0] rdata,
    output ioc_op_t           op
);

    typedef struct packed {
        logic [W-1:0] en;
    } cfg_state_t;

    typedef struct packed {
        logic flag;
    } stat_state_t;

    cfg_state_t  cfg_d, cfg_q;
    stat_state_t stat_d, stat_q;
    logic        flag_rst_n;

    assign flag_rst_n = por_n & rst_n;

    always_comb begin
        op.port_acc = (bus_rd | bus_wr) && (bus_addr == ADDR_W'(REG_PORT));
        op.en_wr    = bus_wr && (bus_addr == ADDR_W'(REG_EN));
        op.flag_clr = bus_wr && (bus_addr == ADDR_W'(REG_FLAG)) && !bus_wdata[FLAG_BIT];
    end

    always_comb begin
        cfg_d = cfg_q;
        if (op.en_wr) begin
            cfg_d.en = bus_wdata[W-1:0];
        end
    end

    // Set wins over clear.
    always_comb begin
        stat_d = stat_q;
        if (op.flag_clr) begin
            stat_d.flag = 1'b0;
        end
        if (mis_any) begin
            stat_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_ff @(posedge clk or negedge flag_rst_n) begin
        if (!flag_rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(REG_PORT)) begin
                rdata[W-1:0] = pin_s;
            end else if (bus_addr == ADDR_W'(REG_EN)) begin
                rdata[W-1:0] = cfg_q.en;
            end else if (bus_addr == ADDR_W'(REG_FLAG)) begin
                rdata[FLAG_BIT] = stat_q.flag;
            end
        end
    end

    assign en   = cfg_q.en;
    assign flag = stat_q.flag;

endmodule

// File: rtl/ioc_mismatch_top.sv
module ioc_mismatch_top
    import ioc_pkg::*;
#(
    parameter int unsigned N_PINS      = 8,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              change_flag,
    output logic              wake_req
);

    localparam int unsigned PRIME = SYNC_STAGES + 1;

    logic [N_PINS-1:0] pin_s;
    logic [N_PINS-1:0] snap;
    logic              snap_valid;
    logic [N_PINS-1:0] en;
    logic [N_PINS-1:0] mis_vec;
    logic              mis_any;
    ioc_op_t           op;

    ioc_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .por_n (por_n),
        .din   (pins_in),
        .dout  (pin_s)
    );

    ioc_snapshot #(.W(N_PINS), .PRIME(PRIME)) snap_i (
        .clk   (clk),
        .por_n (por_n),
        .pin_s (pin_s),
        .load  (op.port_acc),
        .snap  (snap),
        .valid (snap_valid)
    );

    ioc_compare #(.W(N_PINS)) cmp_i (
        .pin_s   (pin_s),
        .snap    (snap),
        .en      (en),
        .valid   (snap_valid),
        .mis_vec (mis_vec),
        .mis_any (mis_any)
    );

    ioc_regs #(.W(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_s     (pin_s),
        .mis_any   (mis_any),
        .en        (en),
        .flag      (change_flag),
        .rdata     (bus_rdata),
        .op        (op)
    );

    assign wake_req = change_flag;

endmodule

// File: rtl/ioc_mismatch_chk.sv
module ioc_mismatch_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         por_n,
    input logic         rst_n,
    input logic         change_flag,
    input logic         wake_req,
    input logic         mis_any,
    input logic         port_acc,
    input logic         en_wr,
    input logic         flag_clr,
    input logic         snap_valid,
    input logic [W-1:0] pin_s,
    input logic [W-1:0] snap,
    input logic [W-1:0] en
);

    p_wake_is_flag_r8: assert property (@(posedge clk) disable iff (!por_n)
        wake_req == change_flag);

    p_set_on_mismatch_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        mis_any |=> change_flag);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        change_flag && !flag_clr |=> change_flag);

    p_clear_works_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        change_flag && flag_clr && !mis_any |=> !change_flag);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !change_flag && !mis_any |=> !change_flag);

    p_snap_load_r5: assert property (@(posedge clk) disable iff (!por_n)
        snap_valid && port_acc |=> snap == $past(pin_s));

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        snap_valid && !port_acc |=> $stable(snap));

    p_en_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
        !en_wr |=> $stable(en));

endmodule

bind ioc_mismatch_top ioc_mismatch_chk #(.W(N_PINS)) chk_i (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .change_flag (change_flag),
    .wake_req    (wake_req),
    .mis_any     (mis_any),
    .port_acc    (op.port_acc),
    .en_wr       (op.en_wr),
    .flag_clr    (op.flag_clr),
    .snap_valid  (snap_valid),
    .pin_s       (pin_s),
    .snap        (snap),
    .en          (en)
);

// File: tb/ioc_mismatch_top_tb_top.sv
`timescale 1ns/1ps
module ioc_mismatch_top_tb_top;

    localparam int W  = 8;
    localparam int AW = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b1;
    logic [W-1:0]  pins = 8'hA5;
    logic          rd = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          change_flag, wake_req;

    int  n_chk = 0, n_bad = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    ioc_mismatch_top dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .pins_in(pins),
        .bus_rd(rd), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .change_flag(change_flag), .wake_req(wake_req)
    );

    // Expected-value model built from the requirements.
    logic [W-1:0] m_s1, m_s2, m_snap, m_en;
    logic         m_flag;
    int           m_cnt;

    function automatic logic [W-1:0] exp_mis(input logic [W-1:0] s, input logic [W-1:0] r,
                                             input logic [W-1:0] e, input int cnt);
        return (cnt >= 3) ? ((s ^ r) & e) : '0;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            2'd0:    return m_s2;
            2'd1:    return m_en;
            2'd2:    return {7'b0, m_flag};
            default: return '0;
        endcase
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_s1 <= '0; m_s2 <= '0; m_snap <= '0; m_en <= '0; m_flag <= 1'b0; m_cnt <= 0;
        end else begin
            logic [W-1:0] mis;
            logic         pacc, clr;
            mis  = exp_mis(m_s2, m_snap, m_en, m_cnt);
            pacc = (rd || wr) && addr == 2'd0;
            clr  = wr && addr == 2'd2 && !wdata[0];
            m_s1 <= pins;
            m_s2 <= m_s1;
            if (m_cnt < 3) begin
                m_snap <= m_s2;
                m_cnt  <= m_cnt + 1;
            end else if (pacc) begin
                m_snap <= m_s2;
            end
            if (wr && addr == 2'd1) m_en <= wdata;
            if (!rst_n)            m_flag <= 1'b0;
            else if (mis != '0)    m_flag <= 1'b1;
            else if (clr)          m_flag <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && !done) begin
            check("R3/R4 flag vs model", {31'b0, change_flag}, {31'b0, m_flag});
            check("R8 wake vs model", {31'b0, wake_req}, {31'b0, m_flag});
        end
    end

    // All tasks start and end at a falling edge.
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        rd = 1'b1; addr = a;
        #1;
        check(req, {24'b0, rdata}, {24'b0, exp});
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0C5EED));
        // Reset state during power-on reset
        idle(3);
        check("R8 flag low in POR", {31'b0, change_flag}, 32'd0);
        check("R8 wake low in POR", {31'b0, wake_req}, 32'd0);
        por_n = 1'b1;
        idle(6);
        mon_on = 1'b1;
        bus_read(2'd1, 8'h00, "R1 enables cleared by POR");
        bus_read(2'd3, 8'h00, "R5 unused address reads 0");

        // R10: non-zero pins at power-up, all enables set, no flag
        bus_write(2'd1, 8'hFF);
        idle(4);
        check("R10 no flag after POR priming", {31'b0, change_flag}, 32'd0);
        bus_write(2'd1, 8'h0F);

        // R2: disabled pin 7 toggles
        pins = 8'h25;
        idle(5);
        check("R2 disabled pin ignored", {31'b0, change_flag}, 32'd0);
        bus_read(2'd0, 8'h25, "R5 port read returns synced pins");

        // R9/R3: enabled pin 0 toggles; flag after third edge
        pins = 8'h24;
        idle(1);
        check("R9 flag low after edge 1", {31'b0, change_flag}, 32'd0);
        idle(1);
        check("R9 flag low after edge 2", {31'b0, change_flag}, 32'd0);
        idle(1);
        check("R3 flag set after edge 3", {31'b0, change_flag}, 32'd1);
        check("R8 wake follows flag", {31'b0, wake_req}, 32'd1);

        // R4: clear blocked while mismatch persists
        bus_write(2'd2, 8'h00);
        check("R4 clear blocked by mismatch", {31'b0, change_flag}, 32'd1);
        bus_write(2'd2, 8'h01);
        check("R4 write of 1 no effect", {31'b0, change_flag}, 32'd1);
        bus_read(2'd0, 8'h24, "R5 port read value");
        bus_read(2'd2, 8'h01, "R4 flag readable");
        bus_write(2'd2, 8'h00);
        check("R4 clear after port read", {31'b0, change_flag}, 32'd0);

        // R6: change lands in the same cycle as the port read
        pins = 8'h26;
        idle(2);
        bus_read(2'd0, 8'h26, "R6 read sees new value");
        check("R6 flag set despite same-cycle read", {31'b0, change_flag}, 32'd1);
        bus_write(2'd2, 8'h00);
        check("R6 clear succeeds after reload", {31'b0, change_flag}, 32'd0);

        // R5: a port write also reloads the snapshot
        pins = 8'h2E;
        idle(4);
        check("R5 flag from pin 3", {31'b0, change_flag}, 32'd1);
        bus_write(2'd0, 8'h5A);
        bus_write(2'd2, 8'h00);
        check("R5 port write reloads snapshot", {31'b0, change_flag}, 32'd0);

        // R7: master reset keeps snapshot, flag returns
        pins = 8'h2A;
        idle(4);
        check("R7 flag before master reset", {31'b0, change_flag}, 32'd1);
        mon_on = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R7 flag cleared by master reset", {31'b0, change_flag}, 32'd0);
        idle(2);
        rst_n = 1'b1;
        #1;
        check("R7 flag low at release", {31'b0, change_flag}, 32'd0);
        idle(1);
        check("R7 flag set again after release", {31'b0, change_flag}, 32'd1);
        mon_on = 1'b1;
        bus_read(2'd1, 8'h0F, "R1 enables survive master reset");
        bus_read(2'd0, 8'h2A, "R5 port read");
        bus_write(2'd2, 8'h00);
        check("R7 clear after service", {31'b0, change_flag}, 32'd0);

        // Random traffic against the model (R2 R3 R4 R5 R6)
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) pins = pins ^ (8'h01 << $urandom_range(0, 7));
            case (op)
                0, 1: begin rd = 1'b1; addr = 2'd0; end
                2:    begin wr = 1'b1; addr = 2'd0; wdata = 8'($urandom()); end
                3:    begin wr = 1'b1; addr = 2'd1; wdata = 8'($urandom()); end
                4, 5: begin wr = 1'b1; addr = 2'd2; wdata = 8'($urandom_range(0, 1)); end
                6:    begin rd = 1'b1; addr = AW'($urandom_range(1, 3)); end
                default: ;
            endcase
            if (rd) begin
                #1;
                check("R5 random read", {24'b0, rdata}, {24'b0, exp_read(addr)});
            end
            @(negedge clk);
            rd = 1'b0; wr = 1'b0;
        end

        idle(2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule